// File: doc/BRIEF.md
# Parallel Host Write Port with Byte-Pair Word Assembly

This block is the write side of a display controller's parallel host port. A static three-bit mode code picks the strobe protocol and the data width. In the enable-strobed protocol a write is taken on the falling edge of the enable line while read/write is low. In the separate-strobe protocol a write is taken on the rising edge of the active-low write strobe. Either protocol can run with a full 16-bit data path or with an 8-bit path on the upper data lines. Chip select gates every write. The strobes are asynchronous to the core clock, so they pass through a synchroniser before their edges are detected.

In the 8-bit modes a byte counter pairs the bytes. The upper byte always comes first. The word is emitted when its lower byte arrives, together with the data/command flag of that lower byte. A host that loses the byte pairing recovers it by writing a zero command byte four times in a row. After that the next byte is taken as an upper byte. A word made of two zero command bytes is kept back as alignment filler and is never passed on.

The outputs are the assembled word, its data/command flag and a valid pulse one clock long. Logic downstream registers the word on that pulse.

Top module: `pbus_word_slave`

## Requirements
- R1: Mode code 000 selects the enable-strobed protocol on the 16-bit path. A falling edge of `hb_en` with `hb_rw` = 0 and `hb_cs_n` = 0 emits `hb_data` and `hb_dc` as one word.
- R2: Mode code 010 selects the separate-strobe protocol on the 16-bit path. A rising edge of `hb_wr_n` with `hb_cs_n` = 0 emits `hb_data` and `hb_dc` as one word. This holds for every data value, including 0000h.
- R3: Mode codes 001 (enable-strobed), 011 and 111 (separate-strobe) select the 8-bit path, where each write carries one byte on `hb_data[15:8]` and `hb_data[7:0]` has no effect. The first byte of a pair is the upper half of the word and produces no output. The second byte completes the word.
- R4: `out_valid` is high for exactly one clock per accepted word. It rises SYNC_STAGES+1 rising clock edges after the strobe edge that completes the word. The 16-bit path takes `out_dc` from its single write, and the 8-bit path takes it from the lower byte.
- R5: A strobe edge is ignored while `hb_cs_n` is high. In the enable-strobed modes it is also ignored while `hb_rw` is high.
- R6: In the 8-bit modes, four consecutive writes of byte 00h with `hb_dc` = 0 produce no word on the fourth write. After them the next byte is an upper byte, whatever the pairing was before.
- R7: In the 8-bit modes, any write that is not a 00h byte with `hb_dc` = 0 restarts the zero-run count. A later run has to be four writes long again.
- R8: In the 8-bit modes, a pair whose two bytes are both 00h with `hb_dc` = 0 emits nothing. A pair of 00h bytes with `hb_dc` = 1 is emitted as 0000h.
- R9: A change of the mode code clears the byte counter, so the next 8-bit byte is an upper byte.
- R10: Mode codes 100, 101 and 110 accept no write on either strobe.
- R11: During and right after reset, `out_valid`, `out_word` and `out_dc` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_pins | input | 3 | Static protocol and width code |
| hb_cs_n | input | 1 | Chip select, active low |
| hb_dc | input | 1 | Data/command flag: 0 command, 1 data |
| hb_wr_n | input | 1 | Write strobe for the separate-strobe protocol, active low |
| hb_en | input | 1 | Enable strobe for the enable-strobed protocol |
| hb_rw | input | 1 | Direction for the enable-strobed protocol, 1 read, 0 write |
| hb_data | input | DATA_W (16) | Host data lines |
| out_word | output | DATA_W (16) | Assembled word |
| out_dc | output | 1 | Data/command flag of the word |
| out_valid | output | 1 | One-clock pulse marking a new word |

## Verification
A completed word is due SYNC_STAGES+1 rising clock edges after the strobe edge that completes it. That is three edges at the default of two synchroniser stages: two for the synchroniser and one for the output register. After each trailing strobe edge the bench watches a fixed window of eight falling clock edges. It counts the valid pulses in that window, records where each one falls and captures the word there. It then requires either exactly one pulse at the third position with the expected word and flag, or no pulse at all. Mode changes are followed by three idle clocks before the next strobe, so the one-cycle clear has taken effect before any byte arrives.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   typedef enum logic [2:0] {
      BUS_OFF   = 3'd0,
      BUS_M68_W = 3'd1,
      BUS_M68_N = 3'd2,
      BUS_I80_W = 3'd3,
      BUS_I80_N = 3'd4
   } bus_mode_e;

   function automatic bus_mode_e decode_mode(input logic [2:0] code);
      case (code)
         3'b000:         return BUS_M68_W;
         3'b001:         return BUS_M68_N;
         3'b010:         return BUS_I80_W;
         3'b011, 3'b111: return BUS_I80_N;
         default:        return BUS_OFF;
      endcase
   endfunction

endpackage

// File: rtl/pbus_mode_reg.sv
module pbus_mode_reg
   import pbus_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_pins,
   output bus_mode_e  mode,
   output logic       narrow,
   output logic       mode_chg
);

   logic [2:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= 3'b000;
      else        code_q <= mode_pins;
   end

   assign mode     = decode_mode(code_q);
   assign narrow   = (mode == BUS_M68_N) || (mode == BUS_I80_N);
   assign mode_chg = (mode_pins != code_q);

endmodule

// File: rtl/pbus_strobe_sync.sv
module pbus_strobe_sync #(
   parameter int                 WIDTH       = 2,
   parameter int                 STAGES      = 2,
   parameter logic [WIDTH-1:0]   IDLE        = '0,
   parameter logic [WIDTH-1:0]   ACTIVE_RISE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] edge_hit
);

   if (STAGES < 2) begin : g_chk_stages
      $error("pbus_strobe_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              last;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= {STAGES{IDLE[b]}};
            last  <= IDLE[b];
         end else begin
            chain <= {chain[STAGES-2:0], din[b]};
            last  <= chain[STAGES-1];
         end
      end

      if (ACTIVE_RISE[b]) begin : g_rise
         assign edge_hit[b] = chain[STAGES-1] & ~last;
      end else begin : g_fall
         assign edge_hit[b] = ~chain[STAGES-1] & last;
      end
   end

endmodule

// File: rtl/pbus_byte_packer.sv
module pbus_byte_packer #(
   parameter int DATA_W  = 16,
   parameter int RUN_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              evt,
   input  logic              narrow,
   input  logic              dc,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] out_word,
   output logic              out_dc,
   output logic              out_valid
);

   localparam int BYTE_W = DATA_W / 2;
   localparam int CNT_W  = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
   localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_LEN - 1);

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_chk_width
      $error("pbus_byte_packer: DATA_W must be even and at least 4");
   end
   if (RUN_LEN < 2) begin : g_chk_run
      $error("pbus_byte_packer: RUN_LEN must be at least 2");
   end

   logic [BYTE_W-1:0] byte_in;
   logic              zero_cmd;
   logic              run_full;
   logic              phase_lo;
   logic              hold_zero;
   logic [BYTE_W-1:0] hold_hi;
   logic [CNT_W-1:0]  run_cnt;

   assign byte_in  = data[DATA_W-1 -: BYTE_W];
   assign zero_cmd = !dc && (byte_in == '0);
   assign run_full = (run_cnt == RUN_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_lo  <= 1'b0;
         hold_zero <= 1'b0;
         hold_hi   <= '0;
         run_cnt   <= '0;
         out_word  <= '0;
         out_dc    <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (clr) begin
            phase_lo  <= 1'b0;
            hold_zero <= 1'b0;
            run_cnt   <= '0;
         end else if (evt) begin
            if (!narrow) begin
               out_word  <= data;
               out_dc    <= dc;
               out_valid <= 1'b1;
            end else if (zero_cmd && run_full) begin
               phase_lo  <= 1'b0;
               hold_zero <= 1'b0;
               run_cnt   <= '0;
            end else begin
               run_cnt <= zero_cmd ? run_cnt + 1'b1 : '0;
               if (!phase_lo) begin
                  hold_hi   <= byte_in;
                  hold_zero <= zero_cmd;
                  phase_lo  <= 1'b1;
               end else begin
                  phase_lo  <= 1'b0;
                  out_word  <= {hold_hi, byte_in};
                  out_dc    <= dc;
                  out_valid <= !(hold_zero && zero_cmd);
               end
            end
         end
      end
   end

   AST_WIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !narrow && !clr) |=> (out_valid && out_word == $past(data) && out_dc == $past(dc))); // R1
   AST_UPPER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && narrow && !clr && !phase_lo) |=> (!out_valid && phase_lo == !$past(zero_cmd && run_full))); // R3
   AST_RESYNC_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && narrow && !clr && zero_cmd && run_full) |=> (!phase_lo && run_cnt == '0 && !out_valid)); // R6
   AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && narrow && !clr && !zero_cmd) |=> (run_cnt == '0)); // R7
   AST_ZERO_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && narrow && !clr && phase_lo && hold_zero && zero_cmd) |=> !out_valid); // R8
   AST_CLR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!phase_lo && !out_valid)); // R9

endmodule

// File: rtl/pbus_word_slave.sv
module pbus_word_slave
   import pbus_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int RUN_LEN     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_pins,
   input  logic              hb_cs_n,
   input  logic              hb_dc,
   input  logic              hb_wr_n,
   input  logic              hb_en,
   input  logic              hb_rw,
   input  logic [DATA_W-1:0] hb_data,
   output logic [DATA_W-1:0] out_word,
   output logic              out_dc,
   output logic              out_valid
);

   localparam int STB_WR = 0;
   localparam int STB_EN = 1;
   localparam logic [1:0] STB_IDLE = 2'b01;
   localparam logic [1:0] STB_RISE = 2'b01;

   bus_mode_e  mode;
   logic       narrow;
   logic       mode_chg;
   logic [1:0] stb_hit;
   logic       wr_evt;

   pbus_mode_reg u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_pins (mode_pins),
      .mode      (mode),
      .narrow    (narrow),
      .mode_chg  (mode_chg)
   );

   pbus_strobe_sync #(
      .WIDTH       (2),
      .STAGES      (SYNC_STAGES),
      .IDLE        (STB_IDLE),
      .ACTIVE_RISE (STB_RISE)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      ({hb_en, hb_wr_n}),
      .edge_hit (stb_hit)
   );

   always_comb begin
      case (mode)
         BUS_M68_W, BUS_M68_N: wr_evt = stb_hit[STB_EN] && !hb_cs_n && !hb_rw;
         BUS_I80_W, BUS_I80_N: wr_evt = stb_hit[STB_WR] && !hb_cs_n;
         default:              wr_evt = 1'b0;
      endcase
   end

   pbus_byte_packer #(
      .DATA_W  (DATA_W),
      .RUN_LEN (RUN_LEN)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (mode_chg),
      .evt       (wr_evt),
      .narrow    (narrow),
      .dc        (hb_dc),
      .data      (hb_data),
      .out_word  (out_word),
      .out_dc    (out_dc),
      .out_valid (out_valid)
   );

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == BUS_OFF) |=> !out_valid); // R10
   AST_CS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (hb_cs_n && !mode_chg) |=> !out_valid); // R5

endmodule

// File: tb/pbus_word_slave_bench.sv
module pbus_word_slave_bench;

   localparam int CLK_P = 10;
   localparam int LAT   = 3;
   localparam int NV    = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mode_pins = 3'b000;
   logic        hb_cs_n = 1'b1;
   logic        hb_dc = 1'b0;
   logic        hb_wr_n = 1'b1;
   logic        hb_en = 1'b0;
   logic        hb_rw = 1'b0;
   logic [15:0] hb_data = 16'h0000;
   logic [15:0] out_word;
   logic        out_dc;
   logic        out_valid;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   pbus_word_slave u_pbus_word_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_pins (mode_pins),
      .hb_cs_n   (hb_cs_n),
      .hb_dc     (hb_dc),
      .hb_wr_n   (hb_wr_n),
      .hb_en     (hb_en),
      .hb_rw     (hb_rw),
      .hb_data   (hb_data),
      .out_word  (out_word),
      .out_dc    (out_dc),
      .out_valid (out_valid)
   );

   // {mode[37:35], dc[34], data[33:18], exp_valid[17], exp_word[16:1], exp_dc[0]}
   localparam logic [37:0] VEC [NV] = '{
      {3'b000, 1'b1, 16'hA5C3, 1'b1, 16'hA5C3, 1'b1},  // R1
      {3'b000, 1'b0, 16'h0012, 1'b1, 16'h0012, 1'b0},  // R1
      {3'b010, 1'b1, 16'h1234, 1'b1, 16'h1234, 1'b1},  // R2
      {3'b010, 1'b0, 16'h0000, 1'b1, 16'h0000, 1'b0},  // R2
      {3'b011, 1'b0, 16'h12FF, 1'b0, 16'h0000, 1'b0},  // R3 upper
      {3'b011, 1'b1, 16'h34AA, 1'b1, 16'h1234, 1'b1},  // R3 R4
      {3'b001, 1'b1, 16'hAB5A, 1'b0, 16'h0000, 1'b0},  // R3 upper
      {3'b001, 1'b1, 16'hCD00, 1'b1, 16'hABCD, 1'b1},  // R3
      {3'b111, 1'b0, 16'h5600, 1'b0, 16'h0000, 1'b0},  // R3 upper
      {3'b111, 1'b0, 16'h7800, 1'b1, 16'h5678, 1'b0}   // R3 R4
   };

   task automatic check(input bit ok, input string tag, input string act, input string exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %s expected %s", tag, act, exp);
      end
   endtask

   task automatic write_chk(input logic [2:0] m, input bit sty68, input logic cs_n,
                            input logic rw, input logic dc, input logic [15:0] d,
                            input bit ev, input logic [15:0] ew, input logic edc,
                            input string tag);
      int n = 0;
      int pos = 0;
      logic [15:0] gw = 16'h0;
      logic gdc = 1'b0;
      @(negedge clk);
      if (mode_pins != m) begin
         mode_pins = m;
         repeat (3) @(negedge clk);
      end
      hb_cs_n = cs_n;
      hb_rw   = rw;
      hb_dc   = dc;
      hb_data = d;
      if (sty68) hb_en = 1'b1; else hb_wr_n = 1'b0;
      repeat (3) @(negedge clk);
      if (sty68) hb_en = 1'b0; else hb_wr_n = 1'b1;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         if (out_valid) begin
            n++;
            pos = i;
            gw  = out_word;
            gdc = out_dc;
         end
      end
      hb_cs_n = 1'b1;
      hb_rw   = 1'b0;
      if (ev)
         check(n == 1 && pos == LAT && gw == ew && gdc == edc, tag,
               $sformatf("pulses=%0d at=%0d word=%h dc=%b", n, pos, gw, gdc),
               $sformatf("pulses=1 at=%0d word=%h dc=%b", LAT, ew, edc));
      else
         check(n == 0, tag, $sformatf("pulses=%0d word=%h", n, gw), "pulses=0");
   endtask

   task automatic wr8(input logic dc, input logic [7:0] b, input bit ev,
                      input logic [15:0] ew, input logic edc, input string tag);
      write_chk(3'b011, 1'b0, 1'b0, 1'b0, dc, {b, 8'h00}, ev, ew, edc, tag);
   endtask

   task automatic realign();
      write_chk(3'b010, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, "R9 realign");
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_word == 16'h0 && out_dc == 1'b0, "R11 in reset",
            $sformatf("v=%b w=%h dc=%b", out_valid, out_word, out_dc), "v=0 w=0000 dc=0");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0 && out_word == 16'h0 && out_dc == 1'b0, "R11 after reset",
            $sformatf("v=%b w=%h dc=%b", out_valid, out_word, out_dc), "v=0 w=0000 dc=0");

      for (int k = 0; k < NV; k++) begin
         logic [37:0] v;
         v = VEC[k];
         write_chk(v[37:35], (v[36] == 1'b0), 1'b0, 1'b0, v[34], v[33:18],
                   v[17], v[16:1], v[0], $sformatf("R1/R2/R3/R4 vector %0d", k));
      end

      // R5: chip select high, and read direction in enable-strobed mode
      write_chk(3'b010, 1'b0, 1'b1, 1'b0, 1'b1, 16'hBEEF, 1'b0, 16'h0, 1'b0, "R5 cs high sep-strobe");
      write_chk(3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 16'hBEEF, 1'b0, 16'h0, 1'b0, "R5 cs high enable");
      write_chk(3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 16'hBEEF, 1'b0, 16'h0, 1'b0, "R5 read cycle");

      // R6: resync from a misaligned state
      realign();
      wr8(1'b1, 8'h99, 1'b0, 16'h0, 1'b0, "R6 stray upper");
      wr8(1'b0, 8'h00, 1'b1, 16'h9900, 1'b0, "R6 zero 1 pairs with stray");
      wr8(1'b0, 8'h00, 1'b0, 16'h0, 1'b0, "R6 zero 2");
      wr8(1'b0, 8'h00, 1'b0, 16'h0, 1'b0, "R6 zero 3");
      wr8(1'b0, 8'h00, 1'b0, 16'h0, 1'b0, "R6 zero 4 resync");
      wr8(1'b1, 8'hAB, 1'b0, 16'h0, 1'b0, "R6 upper after resync");
      wr8(1'b1, 8'hCD, 1'b1, 16'hABCD, 1'b1, "R6 word after resync");

      // R6 aligned run, R8 zero command pairs swallowed
      realign();
      for (int z = 0; z < 4; z++)
         wr8(1'b0, 8'h00, 1'b0, 16'h0, 1'b0, "R6 R8 aligned zero run");
      wr8(1'b0, 8'h12, 1'b0, 16'h0, 1'b0, "R6 upper");
      wr8(1'b0, 8'h34, 1'b1, 16'h1234, 1'b0, "R6 word");

      // R8: zero data bytes are emitted
      realign();
      wr8(1'b1, 8'h00, 1'b0, 16'h0, 1'b0, "R8 zero data upper");
      wr8(1'b1, 8'h00, 1'b1, 16'h0000, 1'b1, "R8 zero data word");

      // R7: a non-matching write restarts the run
      realign();
      wr8(1'b0, 8'h00, 1'b0, 16'h0, 1'b0, "R7 z1");
      wr8(1'b0, 8'h00, 1'b0, 16'h0, 1'b0, "R7 z2");
      wr8(1'b1, 8'h00, 1'b0, 16'h0, 1'b0, "R7 data byte breaks run");
      wr8(1'b0, 8'h00, 1'b1, 16'h0000, 1'b0, "R7 mixed pair emitted");
      wr8(1'b0, 8'h00, 1'b0, 16'h0, 1'b0, "R7 z upper");
      wr8(1'b0, 8'h00, 1'b0, 16'h0, 1'b0, "R7 z lower held");
      wr8(1'b1, 8'h11, 1'b0, 16'h0, 1'b0, "R7 upper");
      wr8(1'b1, 8'h22, 1'b1, 16'h1122, 1'b1, "R7 word");

      // R9: mode change drops a pending upper byte
      realign();
      wr8(1'b1, 8'h44, 1'b0, 16'h0, 1'b0, "R9 pending upper");
      write_chk(3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 16'h5500, 1'b0, 16'h0, 1'b0, "R9 upper after change");
      write_chk(3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 16'h6600, 1'b1, 16'h5566, 1'b1, "R9 word after change");

      // R10: unlisted codes
      write_chk(3'b100, 1'b0, 1'b0, 1'b0, 1'b1, 16'h7777, 1'b0, 16'h0, 1'b0, "R10 code 100 sep-strobe");
      write_chk(3'b101, 1'b1, 1'b0, 1'b0, 1'b1, 16'h7777, 1'b0, 16'h0, 1'b0, "R10 code 101 enable");
      write_chk(3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 16'h7777, 1'b0, 16'h0, 1'b0, "R10 code 110 sep-strobe");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule